// File: doc/BRIEF.md
# SCSI Controller Interrupt Status Unit

This block keeps the three host-visible status registers of a SCSI protocol controller: the status byte, the interrupt-reason byte and the sequence-step byte. It also drives the controller's single interrupt line. A command engine asks for interrupt conditions by presenting one event code for one cycle. Other blocks set and clear the phase and count-zero status bits through bit masks. The host register port reads any register through a byte-wide select and a one-cycle read strobe.

The interrupt line is the registered copy of status bit 7. Raising the interrupt sets that bit and lowering it clears it, so a second raise while the line is already high changes nothing and produces no new edge. Reading the interrupt-reason register is destructive. The host gets the value held before the read, and on the same clock edge the unit clears the reason, clears count-zero, drops the interrupt and loads the sequence step with the "command done" code. A configuration byte holds a bit that suppresses the interrupt on a bus reset. A read-only identification byte is loaded at reset.

Top module: `scsi_isu`

## Requirements
- R1: `irq` always equals status bit 7 as read back through the host port. Raising the interrupt while it is already high leaves `irq` high and creates no further rising edge.
- R2: A read with `rd_sel`=1 (interrupt reason) returns the reason value from before the read. After that edge the reason is 0x00, status bits 7 and 4 are 0, and the sequence step is 4.
- R3: Event code 1 (no response at selection) sets status to 0x00 and then raises the interrupt, so status reads 0x80. It also sets the reason to 0x20 (disconnect, bit 5) and the step to 0.
- R4: Event code 2 (selection with command done) sets the reason to 0x18 (bus service bit 4, function complete bit 3) and the step to 4, and raises the interrupt. Status bits 6:0 are kept.
- R5: Event code 3 (bus reset) sets the reason to 0x80 (reset, bit 7). It raises the interrupt only when configuration bit 6 (report-disable) is 0.
- R6: Event code 4 clears the reason and leaves `irq` unchanged. Event code 5 clears the reason and raises the interrupt.
- R7: Hard reset (`rst_n` low) leaves status, reason and step at 0x00, configuration at 0x07, the identification byte (`rd_sel`=4) at `CHIP_ID` and `irq` low. Read selects are 0 status, 1 reason, 2 step, 3 configuration and 4 identification. Any other select reads 0x00.
- R8: Soft reset, from event code 7 or from `ext_rst`, drops `irq` and restores every hard-reset value, including the configuration.
- R9: `stat_set` and `stat_clr` set and clear status bits 6:0. When both name the same bit, clear wins. Bit 7 can only change through interrupt raise and lower.
- R10: Event code 6 (transfer done) sets status bit 4 (count zero), sets the reason to 0x10 and the step to 0, and raises the interrupt.
- R11: When an event and a reason read fall in the same cycle, the read returns the old reason and the event's values are what remain afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| ext_rst | input | 1 | Synchronous external soft reset |
| evt_valid | input | 1 | Event request strobe |
| evt_code | input | 3 | Event code (1..7) |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| stat_set | input | 7 | Status bits 6:0 to set |
| stat_clr | input | 7 | Status bits 6:0 to clear |
| rd_en | input | 1 | Host read strobe (one cycle per access) |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data, combinational from current state |
| irq | output | 1 | Interrupt line |

## Verification
The bench goes after the destructive reason read. A design that cleared the reason before returning it would read back 0x00 where the old code is expected. A design that skipped count-zero, the step reload or the interrupt drop would show a stale status byte or a step other than 4. The bench issues a second raise while the line is high and counts rising edges, which catches a design that pulses or toggles the line. It runs a bus reset with the report-disable bit set and then clear, which separates a design that ignores that bit. It also places an event in the same cycle as a reason read, and sends soft resets after the configuration has been changed. A design that let the read win the collision, or that kept the configuration through a soft reset, would show the wrong reason or configuration afterwards.

// File: rtl/scsi_isu_pkg.sv
package scsi_isu_pkg;

    localparam int REG_W = 8;
    localparam int MASK_W = REG_W - 1;

    // status byte bit positions
    localparam int ST_IRQ  = 7;
    localparam int ST_CNTZ = 4;

    // reason byte bit positions
    localparam int RN_SELECTED = 0;
    localparam int RN_FDONE    = 3;
    localparam int RN_BSVC     = 4;
    localparam int RN_DISC     = 5;
    localparam int RN_RESET    = 7;

    localparam int CFG_RPT_OFF = 6;

    localparam logic [REG_W-1:0] STEP_CMD_DONE = REG_W'(4);
    localparam logic [REG_W-1:0] CFG_DEFAULT   = REG_W'(7);

    typedef enum logic [2:0] {
        EV_NONE      = 3'd0,
        EV_NORESP    = 3'd1,
        EV_SELCMD    = 3'd2,
        EV_BUSRST    = 3'd3,
        EV_RESEL_ON  = 3'd4,
        EV_RESEL_OFF = 3'd5,
        EV_XFER_DONE = 3'd6,
        EV_SOFT_RST  = 3'd7
    } evt_e;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_REASON = 3'd1,
        SEL_STEP   = 3'd2,
        SEL_CFG    = 3'd3,
        SEL_CHIPID = 3'd4
    } rsel_e;

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] reason;
        logic [REG_W-1:0] step;
        logic [REG_W-1:0] cfg;
        logic [REG_W-1:0] chipid;
    } regs_t;

endpackage

// File: rtl/isu_host_port.sv
module isu_host_port
    import scsi_isu_pkg::*;
(
    input  regs_t              cur,
    input  logic               rd_en,
    input  logic [2:0]         rd_sel,
    input  logic               cfg_we,
    input  logic [REG_W-1:0]   cfg_wdata,
    input  logic [MASK_W-1:0]  stat_set,
    input  logic [MASK_W-1:0]  stat_clr,
    output logic [REG_W-1:0]   rd_data,
    output regs_t              mid
);

    logic reason_rd;

    always_comb begin
        unique case (rd_sel)
            SEL_STATUS: rd_data = cur.status;
            SEL_REASON: rd_data = cur.reason;
            SEL_STEP:   rd_data = cur.step;
            SEL_CFG:    rd_data = cur.cfg;
            SEL_CHIPID: rd_data = cur.chipid;
            default:    rd_data = '0;
        endcase
    end

    assign reason_rd = rd_en && (rd_sel == SEL_REASON);

    always_comb begin
        mid = cur;
        // phase / count bits: clear wins over set, bit 7 untouched
        mid.status[MASK_W-1:0] = (cur.status[MASK_W-1:0] | stat_set) & ~stat_clr;
        if (cfg_we) begin
            mid.cfg = cfg_wdata;
        end
        if (reason_rd) begin
            mid.reason           = '0;
            mid.status[ST_IRQ]   = 1'b0;
            mid.status[ST_CNTZ]  = 1'b0;
            mid.step             = STEP_CMD_DONE;
        end
    end

endmodule

// File: rtl/isu_event_apply.sv
module isu_event_apply
    import scsi_isu_pkg::*;
(
    input  regs_t       mid,
    input  logic        evt_valid,
    input  logic [2:0]  evt_code,
    output regs_t       nxt
);

    localparam logic [REG_W-1:0] R_DISC  = REG_W'(1) << RN_DISC;
    localparam logic [REG_W-1:0] R_SELOK = (REG_W'(1) << RN_BSVC) | (REG_W'(1) << RN_FDONE);
    localparam logic [REG_W-1:0] R_RST   = REG_W'(1) << RN_RESET;
    localparam logic [REG_W-1:0] R_BSVC  = REG_W'(1) << RN_BSVC;

    always_comb begin
        nxt = mid;
        if (evt_valid) begin
            unique case (evt_e'(evt_code))
                EV_NORESP: begin
                    nxt.status         = '0;
                    nxt.status[ST_IRQ] = 1'b1;
                    nxt.reason         = R_DISC;
                    nxt.step           = '0;
                end
                EV_SELCMD: begin
                    nxt.reason         = R_SELOK;
                    nxt.step           = STEP_CMD_DONE;
                    nxt.status[ST_IRQ] = 1'b1;
                end
                EV_BUSRST: begin
                    nxt.reason = R_RST;
                    if (!mid.cfg[CFG_RPT_OFF]) begin
                        nxt.status[ST_IRQ] = 1'b1;
                    end
                end
                EV_RESEL_ON: begin
                    nxt.reason = '0;
                end
                EV_RESEL_OFF: begin
                    nxt.reason         = '0;
                    nxt.status[ST_IRQ] = 1'b1;
                end
                EV_XFER_DONE: begin
                    nxt.status[ST_CNTZ] = 1'b1;
                    nxt.status[ST_IRQ]  = 1'b1;
                    nxt.reason          = R_BSVC;
                    nxt.step            = '0;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/scsi_isu.sv
module scsi_isu
    import scsi_isu_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'h5C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_rst,
    input  logic        evt_valid,
    input  logic [2:0]  evt_code,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_wdata,
    input  logic [6:0]  stat_set,
    input  logic [6:0]  stat_clr,
    input  logic        rd_en,
    input  logic [2:0]  rd_sel,
    output logic [7:0]  rd_data,
    output logic        irq
);

    localparam regs_t RST_VAL = '{
        status: '0,
        reason: '0,
        step:   '0,
        cfg:    CFG_DEFAULT,
        chipid: CHIP_ID
    };

    regs_t r_q, r_d, mid, ev_nxt;
    logic  soft_rst;

    isu_host_port u_host (
        .cur       (r_q),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .stat_set  (stat_set),
        .stat_clr  (stat_clr),
        .rd_data   (rd_data),
        .mid       (mid)
    );

    isu_event_apply u_evt (
        .mid       (mid),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .nxt       (ev_nxt)
    );

    assign soft_rst = ext_rst || (evt_valid && (evt_code == EV_SOFT_RST));

    always_comb begin
        r_d = soft_rst ? RST_VAL : ev_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq = r_q.status[ST_IRQ];

endmodule

// File: rtl/scsi_isu_chk.sv
module scsi_isu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ext_rst,
    input logic        evt_valid,
    input logic [2:0]  evt_code,
    input logic        rd_en,
    input logic [2:0]  rd_sel,
    input logic [7:0]  rd_data,
    input logic        irq
);

    // R1: line and status bit agree
    assert_irq_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 3'd0) |-> (rd_data[7] == irq));

    // R2: reason read drops the line
    assert_read_drops_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 3'd1 && !evt_valid && !ext_rst) |=> !irq);

    // R3: no-response event raises
    assert_noresp_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 3'd1 && !ext_rst) |=> irq);

    // R6: enable-reselection leaves the line alone
    assert_resel_on_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 3'd4 && !ext_rst && !(rd_en && rd_sel == 3'd1)) |=> $stable(irq));

    // R6: disable-reselection raises
    assert_resel_off_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 3'd5 && !ext_rst) |=> irq);

    // R8: soft reset lowers the line
    assert_soft_reset_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst || (evt_valid && evt_code == 3'd7)) |=> !irq);

endmodule

bind scsi_isu scsi_isu_chk i_chk (.*);

// File: tb/test_scsi_isu.sv
module test_scsi_isu;

    localparam logic [7:0] CID = 8'h5C;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ext_rst, evt_valid, cfg_we, rd_en;
    logic [2:0] evt_code, rd_sel;
    logic [7:0] cfg_wdata, rd_data;
    logic [6:0] stat_set, stat_clr;
    logic       irq;

    scsi_isu #(.CHIP_ID(CID)) i_scsi_isu (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst),
        .evt_valid(evt_valid), .evt_code(evt_code),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .stat_set(stat_set), .stat_clr(stat_clr),
        .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t      sb[$];
    item_t      cur_it;
    logic [7:0] got;
    logic       probe = 1'b0;
    int         checks = 0;
    int         fails = 0;
    int         irq_edges = 0;
    bit         done = 1'b0;

    always @(posedge irq) irq_edges++;

    // monitor: samples late in the low phase, before the next rising edge
    always @(negedge clk) begin
        #8;
        if (probe) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty at probe");
            end else begin
                cur_it = sb.pop_front();
                got = cur_it.is_irq ? {7'b0, irq} : rd_data;
                if (got !== cur_it.exp) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", cur_it.tag, got, cur_it.exp);
                end
            end
        end
    end

    task automatic finish_cycle();
        @(negedge clk); #1;
        evt_valid = 0; rd_en = 0; probe = 0; cfg_we = 0;
        stat_set = '0; stat_clr = '0; ext_rst = 0;
    endtask

    task automatic send_evt(input logic [2:0] code);
        @(negedge clk); #1;
        evt_valid = 1; evt_code = code;
        finish_cycle();
    endtask

    task automatic rd(input logic [2:0] sel, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        rd_en = 1; rd_sel = sel; probe = 1;
        sb.push_back('{1'b0, exp, tag});
        finish_cycle();
    endtask

    task automatic peek_irq(input logic e, input string tag);
        @(negedge clk); #1;
        probe = 1; rd_sel = 3'd7;
        sb.push_back('{1'b1, {7'b0, e}, tag});
        finish_cycle();
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk); #1;
        cfg_we = 1; cfg_wdata = v;
        finish_cycle();
    endtask

    task automatic mask(input logic [6:0] s, input logic [6:0] c);
        @(negedge clk); #1;
        stat_set = s; stat_clr = c;
        finish_cycle();
    endtask

    task automatic direct(input int g, input int e, input string tag);
        checks++;
        if (g != e) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, g, e);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    int e0;

    initial begin
        rst_n = 0; ext_rst = 0; evt_valid = 0; evt_code = 0; cfg_we = 0;
        cfg_wdata = 0; stat_set = 0; stat_clr = 0; rd_en = 0; rd_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R7 reset values
        rd(3'd0, 8'h00, "R7 status");
        peek_irq(1'b0, "R7 irq");
        rd(3'd3, 8'h07, "R7 cfg");
        rd(3'd4, CID,   "R7 chip id");
        rd(3'd6, 8'h00, "R7 unused select");
        rd(3'd2, 8'h00, "R7 step");
        rd(3'd1, 8'h00, "R7 reason");
        rd(3'd2, 8'h04, "R2 step after reason read");

        // R4 selection with command, R2 destructive read
        mask(7'h03, 7'h00);
        send_evt(3'd2);
        peek_irq(1'b1, "R4 irq");
        rd(3'd0, 8'h83, "R4 status keeps phase");
        rd(3'd2, 8'h04, "R4 step");
        rd(3'd1, 8'h18, "R2 returns old reason");
        peek_irq(1'b0, "R2 irq dropped");
        rd(3'd1, 8'h00, "R2 reason cleared");
        rd(3'd0, 8'h03, "R1 status bit7 follows");

        // R9 masks, R2 clears count-zero
        mask(7'h10, 7'h00);
        rd(3'd0, 8'h13, "R9 set count zero");
        mask(7'h04, 7'h04);
        rd(3'd0, 8'h13, "R9 clear wins");
        mask(7'h00, 7'h02);
        rd(3'd0, 8'h11, "R9 clear phase bit");
        rd(3'd1, 8'h00, "R2 read");
        rd(3'd0, 8'h01, "R2 count zero cleared");

        // R3 no response
        send_evt(3'd1);
        rd(3'd0, 8'h80, "R3 status");
        rd(3'd2, 8'h00, "R3 step");
        peek_irq(1'b1, "R3 irq");
        // R1 second raise: no new edge
        e0 = irq_edges;
        send_evt(3'd2);
        peek_irq(1'b1, "R1 irq stays high");
        direct(irq_edges, e0, "R1 no extra edge");
        rd(3'd1, 8'h18, "R4 reason");

        // R5 bus reset, report enabled then disabled
        send_evt(3'd3);
        peek_irq(1'b1, "R5 raise when enabled");
        rd(3'd1, 8'h80, "R5 reason");
        cfg_write(8'h47);
        rd(3'd3, 8'h47, "R5 cfg written");
        send_evt(3'd3);
        peek_irq(1'b0, "R5 no raise when disabled");
        rd(3'd1, 8'h80, "R5 reason when disabled");
        cfg_write(8'h07);

        // R6 reselection commands
        send_evt(3'd1);
        send_evt(3'd4);
        peek_irq(1'b1, "R6 enable keeps line");
        rd(3'd1, 8'h00, "R6 enable clears reason");
        peek_irq(1'b0, "R6 line low");
        send_evt(3'd5);
        peek_irq(1'b1, "R6 disable raises");
        rd(3'd1, 8'h00, "R6 disable clears reason");

        // R10 transfer done
        send_evt(3'd6);
        rd(3'd0, 8'h90, "R10 status");
        rd(3'd2, 8'h00, "R10 step");
        rd(3'd1, 8'h10, "R10 reason");

        // R11 event and read in one cycle
        @(negedge clk); #1;
        rd_en = 1; rd_sel = 3'd1; probe = 1;
        evt_valid = 1; evt_code = 3'd1;
        sb.push_back('{1'b0, 8'h00, "R11 read sees old reason"});
        finish_cycle();
        peek_irq(1'b1, "R11 event wins irq");
        rd(3'd1, 8'h20, "R11 event wins reason");

        // R8 soft reset by command
        cfg_write(8'h47);
        mask(7'h05, 7'h00);
        send_evt(3'd2);
        send_evt(3'd7);
        peek_irq(1'b0, "R8 cmd irq low");
        rd(3'd3, 8'h07, "R8 cmd cfg restored");
        rd(3'd0, 8'h00, "R8 cmd status");
        rd(3'd2, 8'h00, "R8 cmd step");
        rd(3'd4, CID,   "R8 cmd chip id");

        // R8 soft reset by external input
        send_evt(3'd1);
        cfg_write(8'h41);
        @(negedge clk); #1;
        ext_rst = 1;
        finish_cycle();
        peek_irq(1'b0, "R8 ext irq low");
        rd(3'd3, 8'h07, "R8 ext cfg restored");
        rd(3'd0, 8'h00, "R8 ext status");
        rd(3'd1, 8'h00, "R8 ext reason");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        summary();
    end

endmodule